// File: doc/BRIEF.md
# SECDED Memory Datapath with Partial Writes and Scrubbing

This block sits between a host request port and a single-ported synchronous store of 72-bit words. Each stored word holds 64 data bits and 8 check bits of an extended Hamming code. Every write gets fresh check bits. Every read is checked, and depending on the integrity mode the block either corrects the word or only reports what it found. Each finding is a one-cycle pulse, either correctable or uncorrectable, and it carries the address of the word.

A write that enables fewer than all eight bytes is turned into a read of the stored word, a byte merge and a full-word write. The host port is held off while this runs. In the scrubbing mode, a read that finds a single-bit error also writes the corrected word back to the same address. The syndrome itself never leaves the block.

Top module: `ecc_rw_path`

## Requirements
- R1: A write with all eight byte enables set is accepted in one cycle and issues one memory write. A later read of that address in any checking mode returns the same 64 data bits with no error pulse.
- R2: In modes 2'b10 and 2'b11, a read of a word with one flipped data bit returns the corrected data. It also raises `ce_pulse` for one cycle, with `err_addr` equal to the read address.
- R3: In modes 2'b10 and 2'b11, a read of a word with two flipped bits raises `ue_pulse` with the read address and returns the stored data bits unchanged.
- R4: In mode 2'b01, both single-bit and double-bit errors raise their pulses, but the returned data is the stored data with no correction.
- R5: In mode 2'b00, no error pulse is ever raised, reads return raw stored data, and every memory write carries all-zero check bits in bits 71:64.
- R6: In mode 2'b11, a read that finds a correctable error writes the corrected word back to the same address in the cycle its response is presented. A second read then finds no error.
- R7: A write with a partial byte mask reads the stored word and replaces only the enabled bytes, where enable bit b covers data bits 8b+7:8b. In modes 2'b10 and 2'b11 the kept bytes come from the corrected word, and a correctable error found on that read raises `ce_pulse`.
- R8: If the read phase of a partial write finds an uncorrectable error in any checking mode, the write is dropped and `ue_pulse` is raised.
- R9: `req_ready` is low from the cycle after a read or a partial write is accepted until that operation ends.
- R10: A flipped check bit is correctable: the data comes back unchanged and `ce_pulse` is raised.
- R11: A memory word is laid out as data in bits 63:0 (stored unmodified), the Hamming bits in 70:64 and overall parity in bit 71. Read data is expected one cycle after a read enable.
- R12: `ce_pulse` and `ue_pulse` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 64 | Read data |
| ce_pulse | output | 1 | Correctable error found |
| ue_pulse | output | 1 | Uncorrectable error found |
| err_addr | output | ADDR_W | Address belonging to the error pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 72 | Memory write word |
| mem_rdata | input | 72 | Memory read word, one cycle after a read enable |

## Verification
The assertions assume two things about the environment. First, the integrity mode stays constant from the acceptance of a request until that operation returns to idle. Second, the memory returns the addressed word exactly one cycle after a read enable. The bench changes the mode only between operations, once the block is idle again. Its store model has a fixed one-cycle read latency. Errors are injected by flipping bits of the modelled store only while the block is idle.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DW     = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int WORD_W = DW + CHK_W;
    localparam int CODE_N = DW + HAM_W;
    localparam int BE_W   = DW / 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_DET   = 2'b01,
        MODE_COR   = 2'b10,
        MODE_SCRUB = 2'b11
    } ecc_mode_e;

    typedef logic [HAM_W-1:0] pos_tab_t [DW];

    // Code position (1..CODE_N, skipping powers of two) of each data bit
    function automatic pos_tab_t build_pos();
        pos_tab_t t;
        int k;
        t = '{default: '0};
        k = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k < DW) t[k] = HAM_W'(p);
                k++;
            end
        end
        return t;
    endfunction

    localparam pos_tab_t POS_TAB = build_pos();

    // Hamming bits are the XOR of the code positions of all set data bits
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DW-1:0] d);
        logic [HAM_W-1:0] h;
        h = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) h = h ^ POS_TAB[i];
        end
        return h;
    endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_pkg::*;
(
    input  logic [DW-1:0]    data_i,
    output logic [CHK_W-1:0] chk_o
);
    logic [HAM_W-1:0] ham;

    always_comb begin
        ham   = ham_bits(data_i);
        chk_o = {(^data_i) ^ (^ham), ham};
    end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DW-1:0]     data_o,
    output logic              ce_o,
    output logic              ue_o
);
    localparam logic [HAM_W-1:0] SYN_MAX = HAM_W'(CODE_N);

    logic [HAM_W-1:0] syn;
    logic             par_odd;

    always_comb begin
        syn     = ham_bits(word_i[DW-1:0]) ^ word_i[DW +: HAM_W];
        par_odd = ^word_i;
        ce_o    = par_odd && (syn <= SYN_MAX);
        ue_o    = (!par_odd && (syn != '0)) || (par_odd && (syn > SYN_MAX));
    end

    for (genvar i = 0; i < DW; i++) begin : g_fix
        assign data_o[i] = word_i[i] ^ (ce_o && (syn == POS_TAB[i]));
    end
endmodule

// File: rtl/ecc_rw_path.sv
module ecc_rw_path
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [7:0]        req_be,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              ce_pulse,
    output logic              ue_pulse,
    output logic [ADDR_W-1:0] err_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [71:0]       mem_wdata,
    input  logic [71:0]       mem_rdata
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_SCRUB, ST_RMW_RD, ST_RMW_WR
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [BE_W-1:0]   be;
        logic              rsp_v;
        logic [DW-1:0]     rsp_d;
        logic              ce;
        logic              ue;
        logic [ADDR_W-1:0] eaddr;
    } regs_t;

    regs_t q, d;
    ecc_mode_e     md;
    logic [DW-1:0]    enc_in;
    logic [CHK_W-1:0] enc_chk;
    logic [DW-1:0]    dec_data;
    logic             dec_ce;
    logic             dec_ue;
    logic [DW-1:0]    base;
    logic             checking;

    assign md = ecc_mode_e'(mode);

    ecc_enc u_enc (.data_i(enc_in), .chk_o(enc_chk));
    ecc_dec u_dec (.word_i(mem_rdata), .data_o(dec_data), .ce_o(dec_ce), .ue_o(dec_ue));

    assign mem_wdata = {(md == MODE_OFF) ? '0 : enc_chk, enc_in};

    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        d.ce     = 1'b0;
        d.ue     = 1'b0;
        req_ready = (q.st == ST_IDLE);
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = q.addr;
        enc_in   = q.data;
        checking = (md != MODE_OFF);
        base     = md[1] ? dec_data : mem_rdata[DW-1:0];
        unique case (q.st)
            ST_IDLE: begin
                mem_addr = req_addr;
                enc_in   = req_wdata;
                if (req_valid) begin
                    mem_en = 1'b1;
                    d.addr = req_addr;
                    d.data = req_wdata;
                    d.be   = req_be;
                    if (!req_write)       d.st = ST_RD;
                    else if (&req_be)     mem_we = 1'b1;
                    else                  d.st = ST_RMW_RD;
                end
            end
            ST_RD: begin
                d.rsp_v = 1'b1;
                d.rsp_d = base;
                d.data  = dec_data;
                d.ce    = checking && dec_ce;
                d.ue    = checking && dec_ue;
                d.eaddr = q.addr;
                d.st    = (md == MODE_SCRUB && dec_ce) ? ST_SCRUB : ST_IDLE;
            end
            ST_SCRUB: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                d.st   = ST_IDLE;
            end
            ST_RMW_RD: begin
                d.ce    = checking && dec_ce;
                d.ue    = checking && dec_ue;
                d.eaddr = q.addr;
                for (int b = 0; b < BE_W; b++) begin
                    d.data[b*8 +: 8] = q.be[b] ? q.data[b*8 +: 8] : base[b*8 +: 8];
                end
                d.st = (checking && dec_ue) ? ST_IDLE : ST_RMW_WR;
            end
            ST_RMW_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
    assign ce_pulse  = q.ce;
    assign ue_pulse  = q.ue;
    assign err_addr  = q.eaddr;

    a_r1_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && (&req_be))
            |-> (mem_en && mem_we && mem_wdata[DW-1:0] == req_wdata));

    a_r5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && md == MODE_OFF) |-> (mem_wdata[71:64] == 8'h00));

    a_r6_scrub_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse && rsp_valid && md == MODE_SCRUB)
            |-> (mem_en && mem_we && mem_addr == err_addr
                 && mem_wdata[DW-1:0] == rsp_rdata));

    a_r8_no_write_after_ue: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RMW_WR) |-> !ue_pulse);

    a_r9_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_ready);

    a_r9_busy_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !(&req_be)) |=> !req_ready);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && ue_pulse));

    a_r12_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |=> !ce_pulse);

    a_r12_ue_single: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |=> !ue_pulse);
endmodule

// File: tb/test_ecc_rw_path.sv
`timescale 1ns/1ps
module test_ecc_rw_path;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_be = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          ce_pulse, ue_pulse;
    logic [AW-1:0] err_addr;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;
    logic [71:0]   mem_rdata;

    logic [71:0]   store [16];
    logic          flip_go = 1'b0;
    logic [3:0]    flip_addr = '0;
    logic [71:0]   flip_mask = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ecc_rw_path #(.ADDR_W(AW)) i_ecc_rw_path (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .err_addr(err_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Store model: one-cycle read latency, bit flips injected while idle
    always @(posedge clk) begin
        if (flip_go) store[flip_addr] <= store[flip_addr] ^ flip_mask;
        else if (mem_en) begin
            if (mem_we) store[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= store[mem_addr[3:0]];
        end
    end

    typedef struct packed {
        logic        wr;
        logic [1:0]  md;
        logic [3:0]  addr;
        logic [63:0] data;
        logic [7:0]  be;
        logic [71:0] flip;
        logic [63:0] exp;
        logic        ce;
        logic        ue;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 4'd1, 64'h0123_4567_89AB_CDEF, 8'hFF, 72'h0, 64'h0, 1'b0, 1'b0, 4'd1},                  // R1
        '{1'b0, 2'd2, 4'd1, 64'h0, 8'h00, 72'h0, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 4'd1},                  // R1
        '{1'b0, 2'd2, 4'd1, 64'h0, 8'h00, 72'h20, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 4'd2},                 // R2, R11
        '{1'b0, 2'd1, 4'd1, 64'h0, 8'h00, 72'h0, 64'h0123_4567_89AB_CDCF, 1'b1, 1'b0, 4'd4},                  // R4
        '{1'b0, 2'd2, 4'd1, 64'h0, 8'h00, 72'h200, 64'h0123_4567_89AB_CFCF, 1'b0, 1'b1, 4'd3},                // R3
        '{1'b1, 2'd2, 4'd2, 64'hFEDC_BA98_7654_3210, 8'hFF, 72'h0, 64'h0, 1'b0, 1'b0, 4'd1},                  // R1
        '{1'b0, 2'd3, 4'd2, 64'h0, 8'h00, 72'h100_0000_0000, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b0, 4'd6},      // R6
        '{1'b0, 2'd2, 4'd2, 64'h0, 8'h00, 72'h0, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, 4'd6},                  // R6
        '{1'b1, 2'd2, 4'd2, 64'h1111_1111_2222_2222, 8'h0F, 72'h0, 64'h0, 1'b0, 1'b0, 4'd7},                  // R7
        '{1'b0, 2'd2, 4'd2, 64'h0, 8'h00, 72'h0, 64'hFEDC_BA98_2222_2222, 1'b0, 1'b0, 4'd7},                  // R7
        '{1'b1, 2'd2, 4'd2, 64'hAAAA_BBBB_0000_0000, 8'hF0, 72'h1, 64'h0, 1'b1, 1'b0, 4'd7},                  // R7
        '{1'b0, 2'd2, 4'd2, 64'h0, 8'h00, 72'h0, 64'hAAAA_BBBB_2222_2222, 1'b0, 1'b0, 4'd7},                  // R7
        '{1'b1, 2'd2, 4'd2, 64'h5555_5555_5555_5555, 8'h01, 72'h6, 64'h0, 1'b0, 1'b1, 4'd8},                  // R8
        '{1'b0, 2'd1, 4'd2, 64'h0, 8'h00, 72'h0, 64'hAAAA_BBBB_2222_2224, 1'b0, 1'b1, 4'd8},                  // R8
        '{1'b1, 2'd0, 4'd3, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF, 72'h0, 64'h0, 1'b0, 1'b0, 4'd5},                  // R5
        '{1'b0, 2'd0, 4'd3, 64'h0, 8'h00, 72'h8, 64'h0F0F_0F0F_F0F0_F0F8, 1'b0, 1'b0, 4'd5},                  // R5
        '{1'b1, 2'd2, 4'd4, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 72'h0, 64'h0, 1'b0, 1'b0, 4'd1},                  // R1
        '{1'b0, 2'd2, 4'd4, 64'h0, 8'h00, 72'h10_0000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 4'd10} // R10
    };

    task automatic check(input bit ok, input string rq, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic inject(input logic [3:0] a, input logic [71:0] m);
        @(negedge clk);
        flip_addr = a;
        flip_mask = m;
        flip_go   = 1'b1;
        @(negedge clk);
        flip_go   = 1'b0;
    endtask

    logic        got_v, got_ce, got_ue;
    logic [63:0] got_d;
    logic [AW-1:0] got_a;

    task automatic issue(input logic wr, input logic [1:0] md, input logic [3:0] a,
                         input logic [63:0] dat, input logic [7:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mode      = md;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = dat;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect();
        got_v = 0; got_ce = 0; got_ue = 0; got_d = '0; got_a = '0;
        for (int k = 0; k < 6; k++) begin
            if (rsp_valid) begin got_v = 1; got_d = rsp_rdata; end
            if (ce_pulse) begin got_ce = 1; got_a = err_addr; end
            if (ue_pulse) begin got_ue = 1; got_a = err_addr; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tag;
        logic [71:0] snap;
        repeat (3) @(negedge clk);
        // Reset state
        check(req_ready === 1'b1, "reset ready", 72'(req_ready), 72'h1);
        check({rsp_valid, ce_pulse, ue_pulse, mem_en} === 4'b0, "reset outputs",
              72'({rsp_valid, ce_pulse, ue_pulse, mem_en}), 72'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d vec%0d", VECS[v].rq, v);
            if (VECS[v].flip != '0) inject(VECS[v].addr, VECS[v].flip);
            issue(VECS[v].wr, VECS[v].md, VECS[v].addr, VECS[v].data, VECS[v].be);
            collect();
            if (!VECS[v].wr) begin
                check(got_v === 1'b1, {tag, " rsp_valid"}, 72'(got_v), 72'h1);
                check(got_d === VECS[v].exp, {tag, " data"}, 72'(got_d), 72'(VECS[v].exp));
            end
            check(got_ce === VECS[v].ce, {tag, " ce"}, 72'(got_ce), 72'(VECS[v].ce));
            check(got_ue === VECS[v].ue, {tag, " ue"}, 72'(got_ue), 72'(VECS[v].ue));
            if (VECS[v].ce || VECS[v].ue)
                check(got_a === AW'(VECS[v].addr), {tag, " err_addr"}, 72'(got_a), 72'(VECS[v].addr));
        end

        // R11: data field stored unmodified in bits 63:0
        check(store[1][63:0] === 64'h0123_4567_89AB_CFCF, "R11 layout",
              72'(store[1][63:0]), 72'h0123_4567_89AB_CFCF);
        // R5: mode-off write stores zero check bits
        check(store[3][71:64] === 8'h00, "R5 zero check bits", 72'(store[3][71:64]), 72'h0);

        // R6: scrub restores the stored word exactly
        issue(1'b1, 2'd3, 4'd5, 64'h3C3C_5A5A_9696_C3C3, 8'hFF);
        collect();
        snap = store[5];
        inject(4'd5, 72'h10_0000);
        issue(1'b0, 2'd3, 4'd5, 64'h0, 8'h00);
        collect();
        check(got_ce === 1'b1, "R6 scrub ce", 72'(got_ce), 72'h1);
        check(store[5] === snap, "R6 store restored", store[5], snap);

        // R9: ready low right after a partial write and after a read are accepted
        issue(1'b1, 2'd2, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80);
        check(req_ready === 1'b0, "R9 busy rmw", 72'(req_ready), 72'h0);
        collect();
        issue(1'b0, 2'd2, 4'd5, 64'h0, 8'h00);
        check(req_ready === 1'b0, "R9 busy read", 72'(req_ready), 72'h0);
        collect();
        check(got_d === 64'hFF3C_5A5A_9696_C3C3, "R7 high byte merge", 72'(got_d), 72'hFF3C_5A5A_9696_C3C3);
        // R12: clean read raises neither pulse
        check({got_ce, got_ue} === 2'b00, "R12 no pulse", 72'({got_ce, got_ue}), 72'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule